// File: doc/BRIEF.md
# Identity Search Engine with CRC-8 Check

This block sits on the master side of a single-wire, open-drain serial bus and finds the 64-bit identity of every slave on it. It does not time the bus waveforms itself. It asks a separate slot generator for one operation at a time: a bus reset, a write slot or a read slot. It then waits for that operation to be acknowledged. In each pass it walks the identity tree one bit position at a time, from the least significant bit. At every position it reads the bit, then reads the bit's complement, then writes the branch it has chosen. Slaves whose bit differs from the written value drop out of the pass.

The engine remembers the deepest position where it took the 0 branch. The next pass then follows the same path up to that point and takes the 1 branch there. This lets the passes cover the whole tree without help from outside. Each completed identity is output with a flag that says whether its top byte matches the CRC-8 (x^8+x^5+x^4+1) of its lower 56 bits.

After a start pulse the engine runs pass after pass until it finds no unexplored branch. It stops early if no slave answers the reset or if every slave falls silent during a pass.

Top module: `idscan_engine`

## Requirements
- R1: After reset the engine is idle: op_req, busy, id_valid, search_done, err_nodev and err_lost are all 0.
- R2: Every pass begins with one reset operation (op_kind = 0). On its acknowledge, op_rbit = 1 means a slave answered. If op_rbit = 0, err_nodev is set, the engine returns to idle, and no identity is output.
- R3: After a reset with a presence answer, the engine issues 8 write slots (op_kind = 1) that carry the search code F0h, least significant bit first.
- R4: For each of the 64 positions, starting at bit 0, the engine issues a read (op_kind = 2) for the true bit, a read for the complement, then a write of the chosen bit.
- R5: When the two reads differ, the written bit equals the value of the first read.
- R6: When both reads are 0, the written bit is chosen as follows. Below the conflict position recorded in the last pass, it repeats that pass's bit. At the recorded position, it is 1. Above it, it is 0. Identities therefore appear in ascending order of their bit-reversed value.
- R7: When both reads are 1, err_lost is set, the pass is abandoned without an identity, and the engine returns to idle.
- R8: At the end of each full pass, id_valid pulses for one cycle. At that time, bit i of id_out is the bit written at position i.
- R9: id_crc_ok is 1 exactly when id_out[63:56] equals the CRC of id_out[55:0]. That CRC uses an initial value of 0, takes bits LSB-first, and applies reflected feedback constant 8Ch.
- R10: A pass that ends with no conflict where the 0 branch was taken sets search_done and leaves the engine idle. Otherwise the next pass starts on its own. A new start pulse clears all flags.
- R11: op_req stays high, with op_kind and op_wbit unchanged, until op_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new enumeration when idle |
| op_ack | input | 1 | One-cycle acknowledge from the slot generator |
| op_rbit | input | 1 | Read value, or presence flag for a reset, valid with op_ack |
| op_req | output | 1 | Operation request to the slot generator |
| op_kind | output | 2 | 0 reset, 1 write, 2 read |
| op_wbit | output | 1 | Bit to write in a write slot |
| id_out | output | ID_BITS | Identity found by the last pass |
| id_valid | output | 1 | One-cycle pulse when id_out is new |
| id_crc_ok | output | 1 | CRC check result for id_out |
| search_done | output | 1 | All branches visited |
| err_nodev | output | 1 | No presence answer after a reset |
| err_lost | output | 1 | All slaves silent during a pass |
| busy | output | 1 | Engine not idle |

## Verification
The bench builds the engine with its default parameters: 64-bit identities, an 8-bit code of F0h and a 56-bit CRC span. This brings two cases within reach: conflicts at bit 0 and at bit 63, and a corrupted top CRC bit that is the only difference between two slaves. A behavioural model of several slaves ANDs their bits onto the bus. It also removes the slaves that do not match each write. The model predicts the enumeration order by sorting the bit-reversed identities. It covers an empty bus, slaves that vanish right after the command, and varied acknowledge delays.

// File: rtl/idscan_pkg.sv
package idscan_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_kind_e;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_RESET   = 3'd1,
        S_CMD     = 3'd2,
        S_RD_TRUE = 3'd3,
        S_RD_COMP = 3'd4,
        S_WRITE   = 3'd5,
        S_FINISH  = 3'd6
    } scan_state_e;

    typedef struct packed {
        logic dir;
        logic mark_zero;
        logic lost;
    } branch_t;

    localparam logic [7:0] CRC_REFL_POLY = 8'h8C;

    function automatic logic [7:0] crc8_shift(input logic [7:0] acc, input logic din);
        logic       fb;
        logic [7:0] nxt;
        fb  = din ^ acc[0];
        nxt = {1'b0, acc[7:1]};
        if (fb) nxt = nxt ^ CRC_REFL_POLY;
        return nxt;
    endfunction

endpackage

// File: rtl/idscan_crc8.sv
module idscan_crc8
    import idscan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       shift_en,
    input  logic       din,
    output logic [7:0] crc
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc <= 8'h00;
        end else if (shift_en) begin
            crc <= crc8_shift(crc, din);
        end
    end

endmodule

// File: rtl/idscan_branch.sv
module idscan_branch
    import idscan_pkg::*;
#(
    parameter int POS_W = 7
) (
    input  logic             rd_true,
    input  logic             rd_comp,
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] last_disc,
    input  logic             prev_bit,
    output branch_t          pick
);

    always_comb begin
        pick.dir       = rd_true;
        pick.mark_zero = 1'b0;
        pick.lost      = rd_true & rd_comp;
        if (!rd_true && !rd_comp) begin
            if (pos < last_disc) begin
                pick.dir = prev_bit;
            end else if (pos == last_disc) begin
                pick.dir = 1'b1;
            end else begin
                pick.dir = 1'b0;
            end
            pick.mark_zero = ~pick.dir;
        end
    end

endmodule

// File: rtl/idscan_store.sv
module idscan_store #(
    parameter int ID_BITS = 64,
    localparam int SEL_W  = $clog2(ID_BITS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   idx,
    input  logic               wr_bit,
    output logic               prev_bit,
    output logic [ID_BITS-1:0] rom
);

    for (genvar g = 0; g < ID_BITS; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                rom[g] <= 1'b0;
            end else if (wr_en && (idx == SEL_W'(g))) begin
                rom[g] <= wr_bit;
            end
        end
    end

    assign prev_bit = rom[idx];

endmodule

// File: rtl/idscan_engine.sv
module idscan_engine
    import idscan_pkg::*;
#(
    parameter int                  ID_BITS  = 64,
    parameter int                  CMD_BITS = 8,
    parameter logic [CMD_BITS-1:0] CMD_CODE = 8'hF0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               op_ack,
    input  logic               op_rbit,
    output logic               op_req,
    output logic [1:0]         op_kind,
    output logic               op_wbit,
    output logic [ID_BITS-1:0] id_out,
    output logic               id_valid,
    output logic               id_crc_ok,
    output logic               search_done,
    output logic               err_nodev,
    output logic               err_lost,
    output logic               busy
);

    localparam int SEL_W   = $clog2(ID_BITS);
    localparam int POS_W   = $clog2(ID_BITS + 1);
    localparam int CMD_W   = $clog2(CMD_BITS);
    localparam int CRC_SPAN = ID_BITS - 8;

    scan_state_e        state;
    logic [SEL_W-1:0]   bit_idx;
    logic [CMD_W-1:0]   cmd_idx;
    logic               t_bit;
    logic               dir_q;
    logic [POS_W-1:0]   last_disc;
    logic [POS_W-1:0]   last_zero;
    logic [POS_W-1:0]   pos;
    op_kind_e           kind_c;
    branch_t            pick;
    logic               prev_bit;
    logic [ID_BITS-1:0] rom;
    logic [7:0]         crc;
    logic               wr_fire;

    assign pos     = POS_W'(bit_idx) + POS_W'(1);
    assign wr_fire = (state == S_WRITE) && op_ack;
    assign busy    = (state != S_IDLE);

    always_comb begin
        op_req  = state inside {S_RESET, S_CMD, S_RD_TRUE, S_RD_COMP, S_WRITE};
        op_wbit = 1'b0;
        case (state)
            S_RESET:              kind_c = OP_RESET;
            S_CMD:   begin        kind_c = OP_WRITE; op_wbit = CMD_CODE[cmd_idx]; end
            S_WRITE: begin        kind_c = OP_WRITE; op_wbit = dir_q; end
            S_RD_TRUE, S_RD_COMP: kind_c = OP_READ;
            default:              kind_c = OP_RESET;
        endcase
        op_kind = kind_c;
    end

    idscan_branch #(.POS_W(POS_W)) u_branch (
        .rd_true   (t_bit),
        .rd_comp   (op_rbit),
        .pos       (pos),
        .last_disc (last_disc),
        .prev_bit  (prev_bit),
        .pick      (pick)
    );

    idscan_store #(.ID_BITS(ID_BITS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_fire),
        .idx      (bit_idx),
        .wr_bit   (dir_q),
        .prev_bit (prev_bit),
        .rom      (rom)
    );

    idscan_crc8 u_crc (
        .clk      (clk),
        .rst      (rst),
        .clear    ((state == S_RESET) && op_ack),
        .shift_en (wr_fire && (bit_idx < SEL_W'(CRC_SPAN))),
        .din      (dir_q),
        .crc      (crc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            bit_idx     <= '0;
            cmd_idx     <= '0;
            t_bit       <= 1'b0;
            dir_q       <= 1'b0;
            last_disc   <= '0;
            last_zero   <= '0;
            id_out      <= '0;
            id_valid    <= 1'b0;
            id_crc_ok   <= 1'b0;
            search_done <= 1'b0;
            err_nodev   <= 1'b0;
            err_lost    <= 1'b0;
        end else begin
            id_valid <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    err_nodev   <= 1'b0;
                    err_lost    <= 1'b0;
                    search_done <= 1'b0;
                    last_disc   <= '0;
                    state       <= S_RESET;
                end
                S_RESET: if (op_ack) begin
                    if (op_rbit) begin
                        cmd_idx   <= '0;
                        bit_idx   <= '0;
                        last_zero <= '0;
                        state     <= S_CMD;
                    end else begin
                        err_nodev <= 1'b1;
                        state     <= S_IDLE;
                    end
                end
                S_CMD: if (op_ack) begin
                    if (cmd_idx == CMD_W'(CMD_BITS - 1)) state <= S_RD_TRUE;
                    else cmd_idx <= cmd_idx + CMD_W'(1);
                end
                S_RD_TRUE: if (op_ack) begin
                    t_bit <= op_rbit;
                    state <= S_RD_COMP;
                end
                S_RD_COMP: if (op_ack) begin
                    if (pick.lost) begin
                        err_lost <= 1'b1;
                        state    <= S_IDLE;
                    end else begin
                        dir_q <= pick.dir;
                        if (pick.mark_zero) last_zero <= pos;
                        state <= S_WRITE;
                    end
                end
                S_WRITE: if (op_ack) begin
                    if (bit_idx == SEL_W'(ID_BITS - 1)) begin
                        state <= S_FINISH;
                    end else begin
                        bit_idx <= bit_idx + SEL_W'(1);
                        state   <= S_RD_TRUE;
                    end
                end
                S_FINISH: begin
                    id_valid  <= 1'b1;
                    id_out    <= rom;
                    id_crc_ok <= (crc == rom[ID_BITS-1 -: 8]);
                    last_disc <= last_zero;
                    if (last_zero == '0) begin
                        search_done <= 1'b1;
                        state       <= S_IDLE;
                    end else begin
                        state <= S_RESET;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (op_req && !op_ack) |=> op_req);

    p_req_stable_r11: assert property (@(posedge clk) disable iff (rst)
        (op_req && !op_ack) |=> ($stable(op_kind) && $stable(op_wbit)));

    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        id_valid |=> !id_valid);

    p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        search_done |-> !op_req);

    p_lost_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        err_lost |-> (!op_req && !id_valid));

    p_nodev_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        err_nodev |-> (!op_req && !id_valid));

    p_write_follows_r5: assert property (@(posedge clk) disable iff (rst)
        ((state == S_RD_COMP) && op_ack && (op_rbit != t_bit))
        |=> (op_kind == 2'd1 && op_wbit == $past(t_bit)));

endmodule

// File: tb/test_idscan_engine.sv
module test_idscan_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        op_ack = 1'b0;
    logic        op_rbit = 1'b0;
    logic        op_req;
    logic [1:0]  op_kind;
    logic        op_wbit;
    logic [63:0] id_out;
    logic        id_valid;
    logic        id_crc_ok;
    logic        search_done;
    logic        err_nodev;
    logic        err_lost;
    logic        busy;

    always #10 clk = ~clk;

    idscan_engine i_idscan_engine (
        .clk(clk), .rst(rst), .start(start), .op_ack(op_ack), .op_rbit(op_rbit),
        .op_req(op_req), .op_kind(op_kind), .op_wbit(op_wbit), .id_out(id_out),
        .id_valid(id_valid), .id_crc_ok(id_crc_ok), .search_done(search_done),
        .err_nodev(err_nodev), .err_lost(err_lost), .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [63:0] dev_id [4];
    bit          dev_ok [4];
    bit          part   [4];
    int          ndev = 0;
    bit          ghost = 0;
    logic [63:0] exp_id [4];
    bit          exp_ok [4];
    int          found = 0;
    int          step = 0;
    int          dly = 0;
    logic [7:0]  cmdv;
    logic        rt, rc;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [55:0] v);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            logic fb = v[i] ^ c[0];
            c = c >> 1;
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    function automatic logic [63:0] make_id(input logic [7:0] fam, input logic [47:0] ser, input bit bad);
        logic [55:0] low = {ser, fam};
        return {ref_crc(low) ^ (bad ? 8'h80 : 8'h00), low};
    endfunction

    function automatic logic [63:0] brev(input logic [63:0] v);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[i] = v[63-i];
        return r;
    endfunction

    task automatic add_dev(input logic [63:0] v);
        dev_id[ndev] = v;
        dev_ok[ndev] = (v[63:56] == ref_crc(v[55:0]));
        ndev++;
    endtask

    // Slave-side bus model: wired AND of participating slaves, pull-up when none drive.
    task automatic respond();
        int b, sub, ek;
        logic v;
        if (step == 0) ek = 0;
        else if (step <= 8) ek = 1;
        else ek = (((step - 9) % 3) == 2) ? 1 : 2;
        if (step == 0) chk(op_kind == 2'(ek), "R2 reset first", 64'(op_kind), 64'(ek));
        else if (step <= 8) chk(op_kind == 2'(ek), "R3 command slot", 64'(op_kind), 64'(ek));
        else chk(op_kind == 2'(ek), "R4 slot order", 64'(op_kind), 64'(ek));
        if (op_kind == 2'd0) begin
            op_rbit = (ndev > 0);
            for (int k = 0; k < 4; k++) part[k] = (k < ndev);
            step = 1;
        end else if (step >= 1 && step <= 8) begin
            cmdv[step-1] = op_wbit;
            if (step == 8) begin
                chk(cmdv == 8'hF0, "R3 code", 64'(cmdv), 64'hF0);
                if (ghost) for (int k = 0; k < 4; k++) part[k] = 0;
            end
            step++;
        end else begin
            b = (step - 9) / 3;
            sub = (step - 9) % 3;
            if (sub < 2) begin
                v = 1'b1;
                for (int k = 0; k < ndev; k++)
                    if (part[k]) v = v & (sub == 0 ? dev_id[k][b] : ~dev_id[k][b]);
                op_rbit = v;
                if (sub == 0) rt = v; else rc = v;
            end else begin
                if (rt != rc) chk(op_wbit == rt, "R5 forced bit", 64'(op_wbit), 64'(rt));
                for (int k = 0; k < ndev; k++)
                    if (dev_id[k][b] != op_wbit) part[k] = 0;
            end
            step++;
            if (step == 9 + 3 * 64) step = 0;
        end
    endtask

    initial begin
        logic [1:0] k0;
        logic       w0;
        forever begin
            @(negedge clk);
            if (op_req && !op_ack && !rst) begin
                k0 = op_kind;
                w0 = op_wbit;
                repeat (dly) @(negedge clk);
                dly = (dly + 1) % 3;
                chk(op_req && op_kind == k0 && op_wbit == w0, "R11 request held",
                    64'({op_req, op_kind, op_wbit}), 64'({1'b1, k0, w0}));
                respond();
                op_ack = 1'b1;
                @(negedge clk);
                op_ack = 1'b0;
            end
        end
    end

    // Per-clock comparison of identity outputs against the predicted order.
    initial begin
        forever begin
            @(negedge clk);
            if (id_valid) begin
                if (found < ndev && !ghost) begin
                    chk(id_out == exp_id[found], "R6 R8 identity order", id_out, exp_id[found]);
                    chk(id_crc_ok == exp_ok[found], "R9 crc flag", 64'(id_crc_ok), 64'(exp_ok[found]));
                end else begin
                    chk(1'b0, "R7 R8 unexpected identity", id_out, 64'h0);
                end
                found++;
            end
        end
    end

    task automatic run(input bit exp_done, input bit exp_nodev, input bit exp_lost, input string name);
        logic [63:0] ti;
        bit to;
        for (int i = 0; i < ndev; i++) begin
            exp_id[i] = dev_id[i];
            exp_ok[i] = dev_ok[i];
        end
        for (int i = 0; i < ndev; i++)
            for (int j = 0; j < ndev - 1 - i; j++)
                if (brev(exp_id[j]) > brev(exp_id[j+1])) begin
                    ti = exp_id[j]; exp_id[j] = exp_id[j+1]; exp_id[j+1] = ti;
                    to = exp_ok[j]; exp_ok[j] = exp_ok[j+1]; exp_ok[j+1] = to;
                end
        step = 0;
        found = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        $display("scenario %s: %0d identities", name, found);
        chk(found == ((exp_nodev || exp_lost) ? 0 : ndev), "R10 identity count", 64'(found), 64'(ndev));
        chk(search_done == exp_done, "R10 done flag", 64'(search_done), 64'(exp_done));
        chk(err_nodev == exp_nodev, "R2 no-device flag", 64'(err_nodev), 64'(exp_nodev));
        chk(err_lost == exp_lost, "R7 lost flag", 64'(err_lost), 64'(exp_lost));
        chk(!op_req, "R10 quiet when idle", 64'(op_req), 64'h0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({op_req, busy, id_valid, search_done, err_nodev, err_lost} == 6'b0,
            "R1 reset state", 64'({op_req, busy, id_valid, search_done, err_nodev, err_lost}), 64'h0);

        ndev = 0; ghost = 0;
        run(0, 1, 0, "empty bus");

        ndev = 0;
        add_dev(make_id(8'h01, 48'h0000_1234_5678, 0));
        run(1, 0, 0, "single");

        ndev = 0;
        add_dev(make_id(8'h01, 48'h0000_1234_5678, 0));
        add_dev(make_id(8'h01, 48'h0000_1234_5679, 1));
        add_dev(make_id(8'h28, 48'hABCD_0000_0001, 0));
        run(1, 0, 0, "three");

        ndev = 0;
        add_dev(make_id(8'h01, 48'h5555_AAAA_0F0F, 0));
        add_dev(make_id(8'h00, 48'h5555_AAAA_0F0F, 0));
        add_dev(make_id(8'h01, 48'h5555_AAAA_0F0F, 1));
        add_dev(make_id(8'hFF, 48'hFFFF_FFFF_FFFF, 0));
        run(1, 0, 0, "edge bits");

        ghost = 1;
        run(0, 0, 1, "vanishing");

        ghost = 0;
        ndev = 0;
        add_dev(make_id(8'h3A, 48'h0102_0304_0506, 0));
        add_dev(make_id(8'h3A, 48'h8102_0304_0506, 0));
        run(1, 0, 0, "restart");

        finish_run();
    end

endmodule